// File: doc/BRIEF.md
# Adaptive Idle Period Predictor

This block estimates how long the next idle stretch of a managed unit will last, using the lengths of the idle stretches it has already seen. At the start of each idle stretch it compares that estimate against a programmable break-even time and raises a recommendation to enter a low-power state only when sleeping is expected to save energy. The break-even time is the idle length at which the energy spent on the shutdown and wake-up transitions, plus the energy of the low state, matches the energy of staying powered. It is only meaningful when it exceeds the sum of the shutdown and wake-up times.

Two update rules are available. The first is a weighted running average with a power-of-two weight, so the update needs only shifts and adds. Idle stretches shorter than the break-even time are filtered out and leave the estimate alone. The second is a backoff rule: a long idle stretch doubles the estimate, and a short one lowers it by a fixed step. All lengths are 16-bit unsigned cycle counts, and they saturate rather than wrap.

Top module: `idle_predictor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `prediction` is 0 and `sleep_go` is 0.
- R2: `sleep_go` takes its new value on the clock edge that samples `idle_start` high, so it is visible one cycle after the strobe. It holds that value until the next `idle_start`, even if `prediction` or the configuration changes meanwhile.
- R3: The value taken by `sleep_go` is 1 only when both of these hold in the strobe cycle: `prediction` > `break_even` (strictly greater), and `break_even` > `t_shutdown` + `t_wakeup` (sum computed without overflow). Otherwise it is 0.
- R4: With `backoff_mode`=0, an `idle_done` pulse whose `idle_len` >= `break_even` sets the prediction to p + ((I−p) >> k) when I >= p, and to p − ((p−I) >> k) otherwise. Here p is the old prediction, I is `idle_len` and k is `weight_shift` (0..7), so the weight is 2^−k.
- R5: With `backoff_mode`=0, an `idle_done` pulse whose `idle_len` < `break_even` leaves the prediction unchanged.
- R6: With `backoff_mode`=1, an `idle_done` pulse whose `idle_len` >= `break_even` doubles the prediction. A prediction of 0 becomes 1.
- R7: With `backoff_mode`=1, an `idle_done` pulse whose `idle_len` < `break_even` lowers the prediction by DEC_STEP (default 256). The result floors at 0.
- R8: The prediction changes only on the clock edge that samples `idle_done` high, and the new value appears on `prediction` in the following cycle.
- R9: Doubling in backoff mode saturates at 65535, and further long idle stretches keep it at 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_start | input | 1 | Strobe: a new idle stretch begins; the sleep decision is taken |
| idle_done | input | 1 | Strobe: an idle stretch has ended and `idle_len` holds its length |
| idle_len | input | 16 | Measured length of the stretch that just ended, in cycles |
| break_even | input | 16 | Break-even idle length, in cycles |
| t_shutdown | input | 16 | Shutdown transition time, in cycles |
| t_wakeup | input | 16 | Wake-up transition time, in cycles |
| weight_shift | input | 3 | Averaging weight exponent k (weight 2^−k) |
| backoff_mode | input | 1 | 0: weighted average with filter; 1: doubling/step-down backoff |
| prediction | output | 16 | Current predicted idle length |
| sleep_go | output | 1 | Recommendation to enter the low-power state |

## Verification
The hardest states to reach from the ports are the saturation ceiling and the zero floor of the backoff rule, since each needs a long run of one-sided idle stretches. The stimulus reaches them with repeated long stretches against a small break-even time, and with repeated short stretches against a large one. It is also hard to show that the decision holds while the estimate moves underneath it. The bench latches a positive decision, then drives prediction-changing `idle_done` pulses with no `idle_start`, and watches `sleep_go` stay put.

// File: rtl/idle_pred_pkg.sv
package idle_pred_pkg;

    localparam int CYC_W   = 16;
    localparam int SHIFT_W = 3;

    typedef logic [CYC_W-1:0]   cyc_t;
    typedef logic [SHIFT_W-1:0] shift_t;

    typedef enum logic {
        MODE_AVERAGE = 1'b0,
        MODE_BACKOFF = 1'b1
    } upd_mode_e;

    typedef struct packed {
        logic valid;
        logic long_idle;
        cyc_t length;
    } idle_sample_t;

    localparam cyc_t CYC_MAX = '1;

    function automatic cyc_t sat_sub(input cyc_t a, input cyc_t b);
        return (a >= b) ? (a - b) : '0;
    endfunction

    function automatic cyc_t sat_double(input cyc_t a);
        logic [CYC_W:0] wide;
        wide = {a, 1'b0};
        if (wide[CYC_W]) return CYC_MAX;
        if (a == '0)     return cyc_t'(1);
        return wide[CYC_W-1:0];
    endfunction

endpackage

// File: rtl/idle_avg_unit.sv
module idle_avg_unit
    import idle_pred_pkg::*;
(
    input  cyc_t   cur,
    input  cyc_t   sample,
    input  shift_t shift,
    output cyc_t   nxt
);
    cyc_t gap;
    cyc_t step;

    always_comb begin
        gap  = (sample >= cur) ? (sample - cur) : (cur - sample);
        step = gap >> shift;
        if (sample >= cur) nxt = cur + step;
        else               nxt = cur - step;
    end
endmodule

// File: rtl/idle_backoff_unit.sv
module idle_backoff_unit
    import idle_pred_pkg::*;
#(
    parameter int DEC_STEP = 256
)(
    input  cyc_t cur,
    input  logic long_idle,
    output cyc_t nxt
);
    localparam cyc_t STEP = cyc_t'(DEC_STEP);

    always_comb begin
        if (long_idle) nxt = sat_double(cur);
        else           nxt = sat_sub(cur, STEP);
    end
endmodule

// File: rtl/idle_sleep_decider.sv
module idle_sleep_decider
    import idle_pred_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  cyc_t pred,
    input  cyc_t thresh,
    input  cyc_t t_down,
    input  cyc_t t_up,
    output logic decide
);
    logic [CYC_W:0] trans_sum;
    logic           cfg_sane;
    logic           worth_it;
    logic           decide_q;

    always_comb begin
        trans_sum = {1'b0, t_down} + {1'b0, t_up};
        cfg_sane  = {1'b0, thresh} > trans_sum;
        worth_it  = cfg_sane && (pred > thresh);
    end

    always_ff @(posedge clk) begin
        if (rst)         decide_q <= 1'b0;
        else if (strobe) decide_q <= worth_it;
    end

    assign decide = decide_q;
endmodule

// File: rtl/idle_predictor.sv
module idle_predictor
    import idle_pred_pkg::*;
#(
    parameter int DEC_STEP  = 256,
    parameter int INIT_PRED = 0
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        idle_start,
    input  logic        idle_done,
    input  logic [15:0] idle_len,
    input  logic [15:0] break_even,
    input  logic [15:0] t_shutdown,
    input  logic [15:0] t_wakeup,
    input  logic [2:0]  weight_shift,
    input  logic        backoff_mode,
    output logic [15:0] prediction,
    output logic        sleep_go
);
    localparam cyc_t PRED_RST = cyc_t'(INIT_PRED);

    idle_sample_t smp;
    upd_mode_e    mode;
    cyc_t         pred_q;
    cyc_t         pred_d;
    cyc_t         avg_nxt;
    cyc_t         bo_nxt;

    always_comb begin
        smp.valid     = idle_done;
        smp.length    = idle_len;
        smp.long_idle = (idle_len >= break_even);
        mode          = upd_mode_e'(backoff_mode);
    end

    idle_avg_unit u_avg (
        .cur    (pred_q),
        .sample (smp.length),
        .shift  (weight_shift),
        .nxt    (avg_nxt)
    );

    idle_backoff_unit #(.DEC_STEP(DEC_STEP)) u_bo (
        .cur       (pred_q),
        .long_idle (smp.long_idle),
        .nxt       (bo_nxt)
    );

    always_comb begin
        pred_d = pred_q;
        if (smp.valid) begin
            unique case (mode)
                MODE_BACKOFF: pred_d = bo_nxt;
                MODE_AVERAGE: if (smp.long_idle) pred_d = avg_nxt;
                default:      pred_d = pred_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pred_q <= PRED_RST;
        else     pred_q <= pred_d;
    end

    idle_sleep_decider u_dec (
        .clk    (clk),
        .rst    (rst),
        .strobe (idle_start),
        .pred   (pred_q),
        .thresh (break_even),
        .t_down (t_shutdown),
        .t_up   (t_wakeup),
        .decide (sleep_go)
    );

    assign prediction = pred_q;
endmodule

// File: rtl/idle_pred_chk.sv
module idle_pred_chk (
    input logic        clk,
    input logic        rst,
    input logic        idle_start,
    input logic        idle_done,
    input logic [15:0] idle_len,
    input logic [15:0] break_even,
    input logic [15:0] t_shutdown,
    input logic [15:0] t_wakeup,
    input logic [2:0]  weight_shift,
    input logic        backoff_mode,
    input logic [15:0] prediction,
    input logic        sleep_go
);
    logic [16:0] trans;
    assign trans = {1'b0, t_shutdown} + {1'b0, t_wakeup};

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !idle_start |=> $stable(sleep_go));

    a_r3_needs_margin: assert property (@(posedge clk) disable iff (rst)
        idle_start && !(prediction > break_even) |=> !sleep_go);

    a_r3_bad_config: assert property (@(posedge clk) disable iff (rst)
        idle_start && ({1'b0, break_even} <= trans) |=> !sleep_go);

    a_r5_filtered: assert property (@(posedge clk) disable iff (rst)
        idle_done && !backoff_mode && (idle_len < break_even) |=> $stable(prediction));

    a_r4_between: assert property (@(posedge clk) disable iff (rst)
        idle_done && !backoff_mode && (idle_len >= break_even) |=>
        (($past(idle_len) >= $past(prediction)) ?
            (prediction >= $past(prediction) && prediction <= $past(idle_len)) :
            (prediction <= $past(prediction) && prediction >= $past(idle_len))));

    a_r6_grows: assert property (@(posedge clk) disable iff (rst)
        idle_done && backoff_mode && (idle_len >= break_even) |=>
        (prediction > $past(prediction)) || (prediction == 16'hFFFF));

    a_r7_shrinks: assert property (@(posedge clk) disable iff (rst)
        idle_done && backoff_mode && (idle_len < break_even) |=>
        prediction <= $past(prediction));

    a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
        !idle_done |=> $stable(prediction));

    a_r1_reset: assert property (@(posedge clk)
        rst |=> (prediction == 16'd0) && !sleep_go);

    logic unused_ok;
    assign unused_ok = ^weight_shift;
endmodule

bind idle_predictor idle_pred_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .idle_start   (idle_start),
    .idle_done    (idle_done),
    .idle_len     (idle_len),
    .break_even   (break_even),
    .t_shutdown   (t_shutdown),
    .t_wakeup     (t_wakeup),
    .weight_shift (weight_shift),
    .backoff_mode (backoff_mode),
    .prediction   (prediction),
    .sleep_go     (sleep_go)
);

// File: tb/tb_idle_predictor.sv
`timescale 1ns/100ps
module tb_idle_predictor;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        idle_start = 1'b0;
    logic        idle_done = 1'b0;
    logic [15:0] idle_len = '0;
    logic [15:0] break_even = 16'd100;
    logic [15:0] t_shutdown = 16'd10;
    logic [15:0] t_wakeup = 16'd20;
    logic [2:0]  weight_shift = '0;
    logic        backoff_mode = 1'b0;
    logic [15:0] prediction;
    logic        sleep_go;

    int errors = 0;
    int checks = 0;
    int p_model = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    idle_predictor dut (
        .clk(clk), .rst(rst), .idle_start(idle_start), .idle_done(idle_done),
        .idle_len(idle_len), .break_even(break_even), .t_shutdown(t_shutdown),
        .t_wakeup(t_wakeup), .weight_shift(weight_shift), .backoff_mode(backoff_mode),
        .prediction(prediction), .sleep_go(sleep_go)
    );

    // mode, k, length, break-even
    localparam logic [35:0] VECS [16] = '{
        {1'b0, 3'd0, 16'd1000,  16'd100},
        {1'b0, 3'd1, 16'd2000,  16'd100},
        {1'b0, 3'd2, 16'd500,   16'd100},
        {1'b0, 3'd1, 16'd50,    16'd100},
        {1'b0, 3'd3, 16'd1250,  16'd1250},
        {1'b0, 3'd7, 16'd60000, 16'd100},
        {1'b0, 3'd0, 16'd300,   16'd2000},
        {1'b0, 3'd4, 16'd200,   16'd150},
        {1'b1, 3'd0, 16'd5000,  16'd1000},
        {1'b1, 3'd0, 16'd900,   16'd1000},
        {1'b1, 3'd2, 16'd1000,  16'd1000},
        {1'b1, 3'd0, 16'd10,    16'd4000},
        {1'b0, 3'd5, 16'd40000, 16'd500},
        {1'b0, 3'd2, 16'd600,   16'd500},
        {1'b1, 3'd0, 16'd200,   16'd300},
        {1'b0, 3'd6, 16'd9,     16'd8}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_next(input bit mode, input int k, input int len, input int be, input int p);
        if (!mode) begin
            if (len < be) return p;
            if (len >= p) return p + ((len - p) >> k);
            return p - ((p - len) >> k);
        end
        if (len >= be) begin
            if (p == 0) return 1;
            return (2 * p > 65535) ? 65535 : 2 * p;
        end
        return (p >= 256) ? p - 256 : 0;
    endfunction

    function automatic bit model_sleep(input int p, input int be, input int sd, input int wu);
        return (p > be) && (be > sd + wu);
    endfunction

    task automatic end_period(input bit mode, input int k, input int len, input int be, input string tag);
        @(negedge clk);
        backoff_mode = mode; weight_shift = 3'(k); break_even = 16'(be);
        idle_len = 16'(len); idle_done = 1'b1;
        p_model = model_next(mode, k, len, be, p_model);
        @(negedge clk);
        idle_done = 1'b0;
        check(prediction == 16'(p_model), tag, prediction, p_model);
    endtask

    task automatic strobe_check(input string tag);
        bit exp;
        exp = model_sleep(p_model, break_even, t_shutdown, t_wakeup);
        idle_start = 1'b1;
        @(negedge clk);
        idle_start = 1'b0;
        check(sleep_go == exp, tag, sleep_go, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(prediction == 16'd0, "R1 reset prediction", prediction, 0);
        check(sleep_go == 1'b0, "R1 reset sleep", sleep_go, 0);
        rst = 1'b0;
        @(negedge clk);
        check(prediction == 16'd0 && !sleep_go, "R1 after release", prediction, 0);

        for (int i = 0; i < 16; i++) begin
            bit m; int k; int len; int be; string tag;
            m = VECS[i][35]; k = int'(VECS[i][34:32]);
            len = int'(VECS[i][31:16]); be = int'(VECS[i][15:0]);
            if (!m) tag = (len >= be) ? "R4 average" : "R5 filter";
            else    tag = (len >= be) ? "R6 double" : "R7 step down";
            end_period(m, k, len, be, tag);
            strobe_check("R3 decision");
        end

        // R8: new length without done strobe
        @(negedge clk); idle_len = 16'd777; backoff_mode = 1'b0; break_even = 16'd1;
        repeat (3) @(negedge clk);
        check(prediction == 16'(p_model), "R8 no strobe", prediction, p_model);

        // R3 equality and config boundaries: force prediction 1000
        end_period(1'b0, 0, 1000, 1000, "R4 k0");
        break_even = 16'd1000; strobe_check("R3 pred equals break-even");
        break_even = 16'd999;  strobe_check("R3 pred above break-even");
        break_even = 16'd30;   strobe_check("R3 break-even equals transitions");
        break_even = 16'd31;   strobe_check("R3 break-even above transitions");
        break_even = 16'd25;   strobe_check("R3 break-even below transitions");

        // R2: latch a yes, then move prediction without a strobe
        break_even = 16'd31; strobe_check("R2 latch");
        end_period(1'b1, 0, 0, 60000, "R7 step down");
        end_period(1'b1, 0, 0, 60000, "R7 step down");
        repeat (2) @(negedge clk);
        check(sleep_go == 1'b1, "R2 held", sleep_go, 1);

        // R7 floor
        for (int i = 0; i < 4; i++) end_period(1'b1, 0, 0, 60000, "R7 floor");
        check(prediction == 16'd0, "R7 at zero", prediction, 0);
        break_even = 16'd31; strobe_check("R2 new decision");
        // R6 from zero
        end_period(1'b1, 0, 5, 1, "R6 from zero");
        // R9 saturation
        for (int i = 0; i < 18; i++) end_period(1'b1, 0, 5, 1, "R9 saturate");
        check(prediction == 16'hFFFF, "R9 ceiling", prediction, 65535);
        end_period(1'b0, 0, 65535, 1, "R4 at ceiling");

        // R1 mid-run reset
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; p_model = 0;
        check(prediction == 16'd0 && !sleep_go, "R1 mid-run reset", prediction, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule